// File: doc/BRIEF.md
# Masked Multi-Level Interrupt Encoder

This block gathers interrupt requests from eleven on-board devices, five active-low open-drain bus request lines and two fatal-condition inputs (power-up and memory parity fault). Sixteen of these sources pass through a write-only mask register. The block reduces the surviving requests to a single priority level for the processor. Only levels 4, 5 and 7 are ever produced, and 7 is the most urgent. Every request is level-sensitive. It counts while its source holds it and disappears as soon as the source lets go, so nothing is latched inside the block.

When the processor acknowledges a level, it offers that level on a valid/ready request channel. The block answers on a valid/ready response channel with the vector address of the lowest-numbered unmasked source that is pending at that level. If nothing is pending there, it answers with a spurious vector. The response is held in a single output register. A new acknowledge is accepted only when that register is empty or is being drained in the same cycle. So `ack_ready = !vec_valid || vec_ready`. While `vec_valid` is high and `vec_ready` is low, `vec_addr` is frozen.

The bus lines are asynchronous and cross a two-flop synchronizer before masking. The device, power-up and parity inputs are already synchronous to `clk`.

Top module: `irq_prio_encoder`

## Requirements
- R1: `ipl` is a registered output. It shows 7 if any level-7 source is pending, else 5 if any unmasked level-5 source is pending, else 4 if any unmasked level-4 source is pending, else 0. It never shows any other value.
- R2: Mask bit i gates source i. A 1 inhibits the source and a 0 lets it through. Bits 0..4 are bus lines 1..5 and bits 5..15 are devices 0..10.
- R3: Reset sets all 16 mask bits to 1. After reset, with every maskable source requesting and no level-7 source active, `ipl` is 0.
- R4: The power-up (`pwr_req`) and parity (`parity_req`) inputs are level 7 and cannot be masked.
- R5: Bus lines are active low and pass two synchronizer flops. A bus line change reaches `ipl` on the third rising edge after it. A device request change reaches `ipl` on the first rising edge.
- R6: Bus lines 1 and 2 are level 4 and bus lines 3 to 5 are level 5. Devices 0 to 5 are level 5 and devices 6 to 10 are level 4.
- R7: The vectors for bus lines 1 to 5 are 0x11C, 0x130, 0x134, 0x138 and 0x13C.
- R8: Device d has vector 0x140+4*d. Power-up has vector 0x0F8 and parity has 0x0FC. Within one level, the lowest-numbered pending source supplies the vector, and power-up ranks ahead of parity.
- R9: An acknowledge at a level with no unmasked pending source, or at a level that no source uses, returns 0x060.
- R10: Requests are not latched. Releasing the last request clears `ipl` back to 0 after the same latency as R5.
- R11: An acknowledge is taken when `ack_valid && ack_ready`. `vec_valid` rises on the next edge. `ack_ready` equals `!vec_valid || vec_ready`. While `vec_valid && !vec_ready`, `vec_addr` holds.
- R12: A write with `mask_wr_en` replaces the whole mask with `mask_wr_data` on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_irq_n | input | 5 | Bus request lines 1..5, active low, asynchronous |
| dev_req | input | 11 | On-board device requests, active high |
| pwr_req | input | 1 | Power-up request, level 7 |
| parity_req | input | 1 | Memory parity fault request, level 7 |
| mask_wr_en | input | 1 | Mask word write strobe |
| mask_wr_data | input | 16 | Mask word, 1 = inhibit |
| ipl | output | 3 | Highest pending level (0, 4, 5 or 7) |
| ack_valid | input | 1 | Acknowledge request valid |
| ack_ready | output | 1 | Acknowledge can be taken |
| ack_level | input | 3 | Level being acknowledged |
| vec_valid | output | 1 | Vector response valid |
| vec_ready | input | 1 | Response consumer ready |
| vec_addr | output | 12 | Vector address of the chosen source |

## Verification
The encoder is tested first with isolated sources, one at a time. This separates the level map and the vector map of each source from the priority logic. Random mixes of requests and masks then make several sources contend at one level and across levels. This shows whether the lowest-index choice and the 7-over-5-over-4 order hold, and whether masking removes a source without disturbing its neighbours. Directed edge-counting stimulus on one bus line and one device tells the synchronizer latency apart from the direct path. A stalled response consumer shows whether a held vector survives changing requests.

// File: rtl/irq_enc_pkg.sv
`timescale 1ns/1ps
package irq_enc_pkg;
  localparam int NUM_BUS  = 5;
  localparam int NUM_DEV  = 11;
  localparam int NUM_SRC  = NUM_BUS + NUM_DEV;
  localparam int VEC_W    = 12;
  localparam int LVL_W    = 3;
  localparam int DEV_HI_N = 6;  // devices below this index sit at level 5

  localparam logic [VEC_W-1:0] VEC_PWR  = 12'h0F8;
  localparam logic [VEC_W-1:0] VEC_PAR  = 12'h0FC;
  localparam logic [VEC_W-1:0] VEC_SPUR = 12'h060;

  // fixed level of maskable source s (bus lines first, then devices)
  function automatic logic [LVL_W-1:0] src_level(input int s);
    if (s < 2)                      return 3'd4;
    else if (s < NUM_BUS)           return 3'd5;
    else if (s - NUM_BUS < DEV_HI_N) return 3'd5;
    else                            return 3'd4;
  endfunction

  function automatic logic [VEC_W-1:0] src_vector(input int s);
    if (s == 0)           return 12'h11C;
    else if (s < NUM_BUS) return 12'h130 + VEC_W'(4 * (s - 1));
    else                  return 12'h140 + VEC_W'(4 * (s - NUM_BUS));
  endfunction
endpackage

// File: rtl/irq_bus_sync.sv
`timescale 1ns/1ps
module irq_bus_sync #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] line_n,
  output logic [N-1:0] req
);
  for (genvar i = 0; i < N; i++) begin : g_line
    logic meta_q, stab_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        meta_q <= 1'b1;
        stab_q <= 1'b1;
      end else begin
        meta_q <= line_n[i];
        stab_q <= meta_q;
      end
    end
    assign req[i] = ~stab_q;

    // R5: a synchronized request appears only if the line was low two edges earlier
    a_r5_sync_delay: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(req[i]) |-> $past(!line_n[i], 2));
  end
endmodule

// File: rtl/irq_mask_reg.sv
`timescale 1ns/1ps
module irq_mask_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] mask
);
  always_ff @(posedge clk) begin
    if (!rst_n)     mask <= '1;
    else if (wr_en) mask <= wr_data;
  end

  a_r12_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(mask));
endmodule

// File: rtl/irq_level_encoder.sv
`timescale 1ns/1ps
module irq_level_encoder
  import irq_enc_pkg::*;
#(
  parameter int NSRC = NUM_SRC
) (
  input  logic [NSRC-1:0]  raw,
  input  logic [NSRC-1:0]  mask,
  input  logic             pwr,
  input  logic             par,
  input  logic [LVL_W-1:0] sel_level,
  output logic [LVL_W-1:0] level,
  output logic             sel_hit,
  output logic [VEC_W-1:0] sel_vec
);
  logic [NSRC-1:0] pend, at4, at5;
  assign pend = raw & ~mask;

  for (genvar s = 0; s < NSRC; s++) begin : g_map
    assign at4[s] = (src_level(s) == 3'd4);
    assign at5[s] = (src_level(s) == 3'd5);
  end

  always_comb begin
    if (pwr || par)           level = 3'd7;
    else if (|(pend & at5))   level = 3'd5;
    else if (|(pend & at4))   level = 3'd4;
    else                      level = 3'd0;
  end

  always_comb begin
    sel_hit = 1'b0;
    sel_vec = VEC_SPUR;
    if (sel_level == 3'd7) begin
      if (pwr)      begin sel_hit = 1'b1; sel_vec = VEC_PWR; end
      else if (par) begin sel_hit = 1'b1; sel_vec = VEC_PAR; end
    end else begin
      for (int s = NSRC - 1; s >= 0; s--) begin
        if (pend[s] && src_level(s) == sel_level) begin
          sel_hit = 1'b1;
          sel_vec = src_vector(s);
        end
      end
    end
  end

  // R1: only unused-free levels come out, and a nonzero level needs a live source
  always_comb begin
    a_r1_level_legal: assert (level == 3'd0 || level == 3'd4 ||
                              level == 3'd5 || level == 3'd7);
    if (level != 3'd0)
      a_r1_no_phantom: assert (pwr || par || (|pend));
  end
endmodule

// File: rtl/irq_prio_encoder.sv
`timescale 1ns/1ps
module irq_prio_encoder
  import irq_enc_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_BUS-1:0] bus_irq_n,
  input  logic [NUM_DEV-1:0] dev_req,
  input  logic               pwr_req,
  input  logic               parity_req,
  input  logic               mask_wr_en,
  input  logic [NUM_SRC-1:0] mask_wr_data,
  output logic [LVL_W-1:0]   ipl,
  input  logic               ack_valid,
  output logic               ack_ready,
  input  logic [LVL_W-1:0]   ack_level,
  output logic               vec_valid,
  input  logic               vec_ready,
  output logic [VEC_W-1:0]   vec_addr
);
  logic [NUM_BUS-1:0] bus_req;
  logic [NUM_SRC-1:0] mask_q;
  logic [LVL_W-1:0]   enc_level;
  logic               sel_hit;
  logic [VEC_W-1:0]   sel_vec;
  logic               accept;

  irq_bus_sync #(.N(NUM_BUS)) u_sync (
    .clk(clk), .rst_n(rst_n), .line_n(bus_irq_n), .req(bus_req));

  irq_mask_reg #(.W(NUM_SRC)) u_mask (
    .clk(clk), .rst_n(rst_n), .wr_en(mask_wr_en),
    .wr_data(mask_wr_data), .mask(mask_q));

  irq_level_encoder #(.NSRC(NUM_SRC)) u_enc (
    .raw({dev_req, bus_req}), .mask(mask_q), .pwr(pwr_req), .par(parity_req),
    .sel_level(ack_level), .level(enc_level), .sel_hit(sel_hit), .sel_vec(sel_vec));

  assign ack_ready = !vec_valid || vec_ready;
  assign accept    = ack_valid && ack_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ipl       <= '0;
      vec_valid <= 1'b0;
      vec_addr  <= '0;
    end else begin
      ipl <= enc_level;
      if (accept) begin
        vec_valid <= 1'b1;
        vec_addr  <= sel_hit ? sel_vec : VEC_SPUR;
      end else if (vec_ready) begin
        vec_valid <= 1'b0;
      end
    end
  end

  a_r4_level7_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_req || parity_req) |=> ipl == 3'd7);
  a_r11_vec_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && !vec_ready) |=> (vec_valid && $stable(vec_addr)));
  a_r11_accept_resp: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && ack_ready) |=> vec_valid);
endmodule

// File: tb/sim_irq_prio_encoder.sv
`timescale 1ns/1ps
module sim_irq_prio_encoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  bus_irq_n = 5'h1F;
  logic [10:0] dev_req = '0;
  logic        pwr_req = 1'b0, parity_req = 1'b0;
  logic        mask_wr_en = 1'b0;
  logic [15:0] mask_wr_data = '0;
  logic [2:0]  ipl;
  logic        ack_valid = 1'b0, ack_ready;
  logic [2:0]  ack_level = '0;
  logic        vec_valid, vec_ready = 1'b1;
  logic [11:0] vec_addr;

  logic [15:0] mask_m = 16'hFFFF;
  int n_vec = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_prio_encoder u0 (.*);

  function automatic logic [2:0] lvl_of(int s);
    if (s < 2) return 3'd4;
    if (s < 5) return 3'd5;
    return (s - 5 < 6) ? 3'd5 : 3'd4;
  endfunction
  function automatic logic [11:0] vec_of(int s);
    logic [11:0] bus_v [5] = '{12'h11C, 12'h130, 12'h134, 12'h138, 12'h13C};
    if (s < 5) return bus_v[s];
    return 12'h140 + 12'(4 * (s - 5));
  endfunction
  function automatic logic [15:0] pend_m();
    return {dev_req, ~bus_irq_n} & ~mask_m;
  endfunction
  function automatic logic [2:0] exp_ipl();
    logic [15:0] p = pend_m();
    logic h4 = 0, h5 = 0;
    if (pwr_req || parity_req) return 3'd7;
    for (int s = 0; s < 16; s++) if (p[s]) begin
      if (lvl_of(s) == 3'd5) h5 = 1; else h4 = 1;
    end
    return h5 ? 3'd5 : (h4 ? 3'd4 : 3'd0);
  endfunction
  function automatic logic [11:0] exp_vec(logic [2:0] l);
    logic [15:0] p = pend_m();
    if (l == 3'd7) return pwr_req ? 12'h0F8 : (parity_req ? 12'h0FC : 12'h060);
    for (int s = 0; s < 16; s++) if (p[s] && lvl_of(s) == l) return vec_of(s);
    return 12'h060;
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic wr_mask(logic [15:0] m);
    @(negedge clk); mask_wr_en = 1; mask_wr_data = m;
    @(negedge clk); mask_wr_en = 0; mask_m = m;
  endtask
  task automatic settle(); repeat (4) @(negedge clk); endtask
  task automatic do_ack(string tag, logic [2:0] l);
    logic [11:0] e;
    @(negedge clk); ack_valid = 1; ack_level = l; vec_ready = 1; e = exp_vec(l);
    @(negedge clk); ack_valid = 0;
    check({tag, " vec_valid"}, vec_valid, 1);
    check({tag, " vec"}, vec_addr, e);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R3 reset ipl", ipl, 0);
    check("R11 reset vec_valid", vec_valid, 0);
    check("R11 reset ack_ready", ack_ready, 1);

    // R3: everything requesting under the reset mask
    bus_irq_n = 5'h00; dev_req = '1; settle();
    check("R3 masked ipl", ipl, 0);
    do_ack("R9 spurious", 3'd4);
    // R4: level 7 is not maskable
    pwr_req = 1; settle(); check("R4 pwr ipl", ipl, 7);
    parity_req = 1; do_ack("R8 pwr over parity", 3'd7);
    pwr_req = 0; settle(); do_ack("R4 parity vec", 3'd7);
    parity_req = 0; bus_irq_n = 5'h1F; dev_req = '0;
    wr_mask(16'h0000); settle();
    check("R10 idle ipl", ipl, 0);

    // R5: bus-line latency is three edges
    @(negedge clk); bus_irq_n[2] = 0;
    @(negedge clk); check("R5 bus edge1", ipl, 0);
    @(negedge clk); check("R5 bus edge2", ipl, 0);
    @(negedge clk); check("R5 bus edge3", ipl, 5);
    do_ack("R7 bus3 vec", 3'd5);
    bus_irq_n[2] = 1; settle(); check("R10 release", ipl, 0);
    // R5: device latency is one edge
    @(negedge clk); dev_req[7] = 1;
    @(negedge clk); check("R5 dev edge1", ipl, 4);
    do_ack("R8 dev7 vec", 3'd4);
    dev_req[7] = 0;

    // R6/R7/R8: each source alone
    for (int s = 0; s < 16; s++) begin
      bus_irq_n = 5'h1F; dev_req = '0;
      if (s < 5) bus_irq_n[s] = 0; else dev_req[s-5] = 1;
      settle();
      check($sformatf("R6 src%0d level", s), ipl, lvl_of(s));
      do_ack($sformatf("R7 R8 src%0d", s), lvl_of(s));
    end
    // R2: masking one source leaves the other
    bus_irq_n = 5'h1F; dev_req = 11'h001; bus_irq_n[3] = 0;
    wr_mask(16'h0020); settle();
    check("R2 mask dev0", ipl, 5);
    do_ack("R2 bus4 vec", 3'd5);
    wr_mask(16'h0008); settle();
    do_ack("R2 dev0 vec", 3'd5);
    do_ack("R9 unused level", 3'd6);

    // R11: back-pressure
    @(negedge clk); ack_valid = 1; ack_level = 3'd5; vec_ready = 0;
    @(negedge clk); ack_valid = 0;
    check("R11 valid", vec_valid, 1);
    check("R11 ack_ready low", ack_ready, 0);
    check("R11 vec", vec_addr, 12'h140);
    dev_req = '0; bus_irq_n = 5'h1F; pwr_req = 1;
    ack_valid = 1; ack_level = 3'd7;
    repeat (3) @(negedge clk);
    check("R11 held", vec_addr, 12'h140);
    ack_valid = 0; vec_ready = 1;
    @(negedge clk); check("R11 drained", vec_valid, 0);
    pwr_req = 0;

    // R12 + random mix
    for (int i = 0; i < 300; i++) begin
      wr_mask(16'($urandom));
      bus_irq_n = 5'($urandom); dev_req = 11'($urandom);
      pwr_req = ($urandom % 8) == 0; parity_req = ($urandom % 8) == 0;
      settle();
      check("R1 R12 random ipl", ipl, exp_ipl());
      case ($urandom % 4)
        0: do_ack("R8 random", 3'd4);
        1: do_ack("R8 random", 3'd5);
        2: do_ack("R8 random", 3'd7);
        default: do_ack("R9 random", 3'($urandom));
      endcase
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        n_vec++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
  initial $urandom(32'd1234);
endmodule